// File: doc/BRIEF.md
# ALU Condition Flag Generator

This block derives the four integer condition flags from one ALU operation: carry, zero, negative and overflow. Its inputs are the two operands, the result word, a second (upper) result word, and an operation class. The arithmetic itself is done elsewhere. The block assumes that the result it receives is consistent with the operands. For example, on an add the low result word equals the operands' sum truncated to the word width.

The flag rules change with the class of operation:

- **Subtract and compare:** carry reports a borrow, not the adder carry.
- **Compare:** negative reports the true sign of the difference, even when the subtraction overflowed.
- **Move:** the overflow position instead reports whether the moved word is a floating-point NaN.
- **Double-word result:** zero is tested across both result words.

A thin registered wrapper latches the flags once per clock. This lets the flags be observed at a clock boundary. The flags are packed into a four-bit vector whose bit positions are fixed.

Top module: `cond_flag_gen`

## Requirements
- R1: The flag vector is {V, N, Z, C} at bits 3, 2, 1, 0. The op codes are add=0, subtract=1, compare=2, move=3, double-word=4. On add, C equals the unsigned carry out of the top operand bit.
- R2: On subtract and compare, C is set exactly when opa is less than opb as unsigned numbers (a borrow).
- R3: For op codes 0 to 3, Z is set exactly when every bit of the low result word is zero, whatever the carry and overflow are.
- R4: On double-word (code 4), Z is set only when both result words are all zero. N equals the top bit of the upper word. C and V are 0.
- R5: On compare, N is set exactly when opa is less than opb as signed two's-complement numbers, including cases where the subtraction overflows.
- R6: On add, subtract and move, N equals the top bit of the low result word. After an overflow this is the inverted true sign.
- R7: On add, V is set when the operands share a sign and the result sign differs from it.
- R8: On subtract and compare, V is set when the operand signs differ and the result sign differs from opa's sign.
- R9: On move, C is 0 and V is set exactly when the low result word is a NaN. A NaN has all exponent-field bits set (the EXP_W bits just below the sign bit) and a nonzero mantissa (the remaining low bits).
- R10: Unused op codes 5 to 7 give all four flags 0.
- R11: Flags appear on flags_o one clock after the inputs are presented. A synchronous active-low reset clears flags_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation class code |
| opa_i | input | DATA_W | First operand |
| opb_i | input | DATA_W | Second operand |
| res_lo_i | input | DATA_W | Result word (low word for double-word) |
| res_hi_i | input | DATA_W | Upper result word, used only on double-word |
| flags_o | output | 4 | Registered {V, N, Z, C} |

## Verification
The bench builds the block with DATA_W = 6 and EXP_W = 3, which gives a six-bit word with a two-bit mantissa. At this width every operand pair can be swept for add, subtract and compare. That sweep reaches every signed-overflow case, every borrow case and both zero outcomes. The same width also allows all 64 move values to be applied, so every NaN, infinity and ordinary encoding is covered. All 4096 upper/lower word pairs are swept for the double-word class, so a zero in only one of the two words is exercised. The unused op codes and reset behaviour are also checked.

// File: rtl/cfg_pkg.sv
// Package: shared operation-class encoding and flag bit positions.
// Assumes a three-bit op code; codes 5..7 are unused.
package cfg_pkg;
    typedef enum logic [2:0] {
        OPC_ADD  = 3'd0,
        OPC_SUB  = 3'd1,
        OPC_CMP  = 3'd2,
        OPC_MOV  = 3'd3,
        OPC_WIDE = 3'd4
    } opc_t;

    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
    localparam int FLAG_W = 4;
endpackage

// File: rtl/cfg_carry_ovf.sv
// Module: carry, borrow and signed overflow from operand and result sign bits.
// Assumes res = opa + opb (add view) or res = opa - opb (subtract view).
module cfg_carry_ovf #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] res,
    output logic         add_c,
    output logic         add_v,
    output logic         sub_b,
    output logic         sub_v
);
    localparam int MSB = W - 1;

    logic am, bm, rm;

    // Derive top-bit carries from sign bits: carry-in to MSB equals a^b^r.
    always_comb begin
        am    = opa[MSB];
        bm    = opb[MSB];
        rm    = res[MSB];
        add_c = (am & bm) | ((am | bm) & ~rm);
        sub_b = (~am & bm) | ((~am | bm) & rm);
        add_v = (am == bm) & (rm != am);
        sub_v = (am != bm) & (rm != am);
    end
endmodule

// File: rtl/cfg_nan_detect.sv
// Module: NaN test on a packed float word with EXP_W exponent bits under the sign.
// Assumes W >= EXP_W + 2 so the mantissa has at least one bit.
module cfg_nan_detect #(
    parameter int W     = 32,
    parameter int EXP_W = 8
) (
    input  logic [W-1:0] val,
    output logic         is_nan
);
    localparam int MAN_W = W - 1 - EXP_W;
    localparam int EXP_LO = MAN_W;

    logic [EXP_W-1:0] expf;
    logic [MAN_W-1:0] manf;

    // Split fields and flag all-ones exponent with nonzero mantissa.
    always_comb begin
        expf   = val[EXP_LO +: EXP_W];
        manf   = val[MAN_W-1:0];
        is_nan = (&expf) & (|manf);
    end
endmodule

// File: rtl/cfg_flag_mux.sv
// Module: selects C, Z, N, V per operation class from precomputed terms.
// Assumes terms from cfg_carry_ovf and cfg_nan_detect for the same inputs.
module cfg_flag_mux
    import cfg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]        op,
    input  logic [W-1:0]      res_lo,
    input  logic [W-1:0]      res_hi,
    input  logic              add_c,
    input  logic              add_v,
    input  logic              sub_b,
    input  logic              sub_v,
    input  logic              is_nan,
    output logic [FLAG_W-1:0] flags
);
    localparam int MSB = W - 1;

    logic lo_zero, hi_zero;

    // Zero detection per result word.
    always_comb begin
        lo_zero = (res_lo == '0);
        hi_zero = (res_hi == '0);
    end

    // Class-dependent flag selection.
    always_comb begin
        flags = '0;
        case (opc_t'(op))
            OPC_ADD: begin
                flags[FLAG_C] = add_c;
                flags[FLAG_V] = add_v;
                flags[FLAG_N] = res_lo[MSB];
                flags[FLAG_Z] = lo_zero;
            end
            OPC_SUB: begin
                flags[FLAG_C] = sub_b;
                flags[FLAG_V] = sub_v;
                flags[FLAG_N] = res_lo[MSB];
                flags[FLAG_Z] = lo_zero;
            end
            OPC_CMP: begin
                flags[FLAG_C] = sub_b;
                flags[FLAG_V] = sub_v;
                flags[FLAG_N] = res_lo[MSB] ^ sub_v;
                flags[FLAG_Z] = lo_zero;
            end
            OPC_MOV: begin
                flags[FLAG_V] = is_nan;
                flags[FLAG_N] = res_lo[MSB];
                flags[FLAG_Z] = lo_zero;
            end
            OPC_WIDE: begin
                flags[FLAG_N] = res_hi[MSB];
                flags[FLAG_Z] = lo_zero & hi_zero;
            end
            default: flags = '0;
        endcase
    end
endmodule

// File: rtl/cond_flag_gen.sv
// Module: top; computes condition flags and registers them once per clock.
// Assumes the result inputs match the operands for the chosen class.
module cond_flag_gen
    import cfg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [DATA_W-1:0] res_lo_i,
    input  logic [DATA_W-1:0] res_hi_i,
    output logic [3:0]        flags_o
);
    logic              add_c, add_v, sub_b, sub_v, is_nan;
    logic [FLAG_W-1:0] flags_d;

    cfg_carry_ovf #(.W(DATA_W)) u_cov (
        .opa(opa_i), .opb(opb_i), .res(res_lo_i),
        .add_c(add_c), .add_v(add_v), .sub_b(sub_b), .sub_v(sub_v)
    );

    cfg_nan_detect #(.W(DATA_W), .EXP_W(EXP_W)) u_nan (
        .val(res_lo_i), .is_nan(is_nan)
    );

    cfg_flag_mux #(.W(DATA_W)) u_mux (
        .op(op_i), .res_lo(res_lo_i), .res_hi(res_hi_i),
        .add_c(add_c), .add_v(add_v), .sub_b(sub_b), .sub_v(sub_v),
        .is_nan(is_nan), .flags(flags_d)
    );

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= flags_d;
    end

    // Checking support: one-cycle-after-active marker and reference terms.
    logic            live_q;
    logic [DATA_W:0] sum_chk;
    logic            slt_chk, ult_chk;

    // Track whether the last edge captured real inputs.
    always_ff @(posedge clk) begin
        live_q <= rst_n;
    end

    // Reference arithmetic computed from the ports.
    always_comb begin
        sum_chk = {1'b0, opa_i} + {1'b0, opb_i};
        slt_chk = $signed(opa_i) < $signed(opb_i);
        ult_chk = opa_i < opb_i;
    end

    a_r11_reset_clear: assert property (@(posedge clk)
        !$past(rst_n) |-> flags_o == 4'b0);

    a_r1_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 3'd0) |-> flags_o[0] == $past(sum_chk[DATA_W]));

    a_r2_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(op_i) == 3'd1 || $past(op_i) == 3'd2))
        |-> flags_o[0] == $past(ult_chk));

    a_r5_cmp_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 3'd2) |-> flags_o[2] == $past(slt_chk));

    a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) < 3'd4 && $past(res_lo_i) == '0) |-> flags_o[1]);

    a_r9_move_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 3'd3) |-> !flags_o[0]);

    a_r10_unused: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) > 3'd4) |-> flags_o == 4'b0);
endmodule

// File: tb/sim_cond_flag_gen.sv
module sim_cond_flag_gen;
    localparam int W   = 6;
    localparam int EW  = 3;
    localparam int SZ  = 1 << W;
    localparam int MSK = SZ - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op = '0;
    logic [W-1:0] a = '0, b = '0, rlo = '0, rhi = '0;
    logic [3:0]   flags;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cond_flag_gen #(.DATA_W(W), .EXP_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(a), .opb_i(b),
        .res_lo_i(rlo), .res_hi_i(rhi), .flags_o(flags)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (op=%0d a=%0d b=%0d lo=%0d hi=%0d)",
                     tag, got, exp, op, a, b, rlo, rhi);
        end
    endtask

    // Present one vector at a falling edge, sample at the next falling edge.
    task automatic apply(input int o, input int va, input int vb, input int lo, input int hi);
        op  = 3'(o);
        a   = W'(va);
        b   = W'(vb);
        rlo = W'(lo);
        rhi = W'(hi);
        @(negedge clk);
    endtask

    function automatic int sgn(input int v);
        return (v >= SZ/2) ? v - SZ : v;
    endfunction

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R11: reset clears, even with nonzero inputs pending.
        op = 3'd4; rhi = '1;
        repeat (3) @(negedge clk);
        chk("R11 reset flags", flags == 4'b0, 1'b1);
        rst_n = 1'b1;

        // Add / subtract / compare exhaustive.
        for (int o = 0; o < 3; o++) begin
            for (int x = 0; x < SZ; x++) begin
                for (int y = 0; y < SZ; y++) begin
                    int r, sr, tr;
                    logic ev, en;
                    if (o == 0) begin
                        r  = (x + y) & MSK;
                        tr = sgn(x) + sgn(y);
                    end else begin
                        r  = (x - y) & MSK;
                        tr = sgn(x) - sgn(y);
                    end
                    sr = sgn(r);
                    ev = (tr != sr);
                    apply(o, x, y, r, (x ^ 21) & MSK);
                    if (o == 0) begin
                        chk("R1 add carry", flags[0], (x + y) >= SZ);
                        chk("R7 add overflow", flags[3], ev);
                        chk("R6 add negative", flags[2], r >= SZ/2);
                    end else begin
                        chk("R2 borrow", flags[0], x < y);
                        chk("R8 sub overflow", flags[3], ev);
                        if (o == 2) begin
                            en = (tr < 0);
                            chk("R5 compare sign", flags[2], en);
                        end else begin
                            chk("R6 sub negative", flags[2], r >= SZ/2);
                        end
                    end
                    chk("R3 zero", flags[1], r == 0);
                end
            end
        end

        // Move: every value.
        for (int v = 0; v < SZ; v++) begin
            int ex, mn;
            ex = (v >> (W - 1 - EW)) & ((1 << EW) - 1);
            mn = v & ((1 << (W - 1 - EW)) - 1);
            apply(3, (v * 7) & MSK, (v * 3) & MSK, v, MSK);
            chk("R9 move carry", flags[0], 1'b0);
            chk("R9 move nan", flags[3], (ex == (1 << EW) - 1) && (mn != 0));
            chk("R6 move negative", flags[2], v >= SZ/2);
            chk("R3 move zero", flags[1], v == 0);
        end

        // Double-word: every upper/lower pair.
        for (int h = 0; h < SZ; h++) begin
            for (int l = 0; l < SZ; l++) begin
                apply(4, 0, 0, l, h);
                chk("R4 wide zero", flags[1], (h == 0) && (l == 0));
                chk("R4 wide negative", flags[2], h >= SZ/2);
                chk("R4 wide carry/overflow", flags[0] | flags[3], 1'b0);
            end
        end

        // Unused codes with inputs that would set flags under other codes.
        for (int o = 5; o < 8; o++) begin
            apply(o, MSK, 1, 0, 0);
            chk("R10 unused code", flags == 4'b0, 1'b1);
            apply(o, 32, 32, 32, MSK);
            chk("R10 unused code", flags == 4'b0, 1'b1);
        end

        // R11: one-cycle latency and synchronous reset mid-run.
        apply(0, MSK, 1, 0, 0);
        chk("R11 latency set", flags == 4'b0011, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 sync reset", flags == 4'b0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after release", flags == 4'b0011, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule